// File: doc/BRIEF.md
# Slow Clock Source Switch Sequencer

This block chooses which oscillator drives the low-frequency system clock. Out of power-on reset the internal RC oscillator is enabled and feeds the slow clock output. The crystal oscillator stays disabled. A single control write that carries the crystal-select bit starts a one-way move to the crystal. The block first asks the pin multiplexer to give the two crystal pins to the oscillator. It then enables the crystal and lets it settle for a fixed number of RC slow clock cycles. After that it hands the output over to the crystal without shortening any clock phase, and finally turns the RC oscillator off.

A status output goes high once the crystal drives the slow clock. From then on nothing except another power-on reset brings the RC source back. A separate mode write can mark the crystal input as an externally supplied clock (bypass) instead of a resonator. Writes are single-cycle strobes that are synchronous to the RC slow clock.

Top module: `slowclk_src_seq`

## Requirements
- R1: While por_n is low and at the first cycle after it rises: rc_en=1, xtal_en=0, pinmux_req=0, xtal_bypass=0, sw_done=0, and slow_clk follows rc_clk.
- R2: A write (ctrl_wr=1) with ctrl_xtalsel=1 raises pinmux_req on the rc_clk cycle after the write edge, and xtal_en one cycle later. A write with ctrl_xtalsel=0 changes nothing.
- R3: The handover starts exactly 2^SETTLE_W (default 32768) rc_clk cycles after xtal_en rises. slow_clk keeps following rc_clk for the first two cycles of the handover, and rc_en stays 1 until the crystal has taken over.
- R4: slow_clk never shows a high or low phase shorter than the shorter half period of the two sources, and the RC and crystal legs are never connected at the same time.
- R5: After the handover, rc_en=0 and slow_clk follows xtal_clk.
- R6: sw_done rises within a few source cycles after the handover starts, and only once the crystal drives slow_clk.
- R7: A crystal-select write made after the sequence has started or finished is ignored: the settle count is not restarted and sw_done stays 1.
- R8: Only por_n brings the RC source back. Pulsing por_n low after completion restores every output listed in R1.
- R9: A write with mode_wr=1 loads mode_bypass into xtal_bypass on the next cycle while the sequence is idle. Once pinmux_req is high, mode writes are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| por_n | input | 1 | Asynchronous power-on reset, active low |
| rc_clk | input | 1 | Internal RC oscillator clock; also clocks the control logic |
| xtal_clk | input | 1 | Crystal oscillator output or external bypass clock |
| ctrl_wr | input | 1 | Control write strobe, one rc_clk cycle |
| ctrl_xtalsel | input | 1 | Crystal-select data bit of the control write |
| mode_wr | input | 1 | Mode write strobe, one rc_clk cycle |
| mode_bypass | input | 1 | Bypass data bit of the mode write |
| rc_en | output | 1 | Enable for the RC oscillator |
| xtal_en | output | 1 | Enable for the crystal oscillator |
| xtal_bypass | output | 1 | Crystal input treated as an external clock |
| pinmux_req | output | 1 | Request to route the crystal pins to the oscillator |
| slow_clk | output | 1 | Glitch-free slow clock output |
| sw_done | output | 1 | Switch sequence finished, crystal in use |

## Verification
Every strobe is driven on an rc_clk falling edge, so it is taken at the next rising edge, which is cycle N. pinmux_req and xtal_bypass are due at N, and xtal_en at N+1. At N+32770 slow_clk must still rise with rc_clk, and at N+32771 it must not. A scoreboard queue stores each expectation with its absolute cycle, and the monitor compares it half a nanosecond or more after that rising edge. sw_done depends on synchronizers in both clock domains, so it is checked against a time bound. After that, rc_clk has stopped, and the checks move to xtal_clk edges and fixed delays.

// File: rtl/slowclk_pkg.sv
`timescale 1ns/1ps
package slowclk_pkg;

  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_PINMUX,
    SQ_SETTLE,
    SQ_HANDOVER,
    SQ_XTAL
  } seq_state_e;

  // last count value of a settle timer of the given width (wrap point)
  function automatic int unsigned settle_last(input int unsigned width);
    return (32'd1 << width) - 32'd1;
  endfunction

  // total settle length in slow clock cycles
  function automatic int unsigned settle_cycles(input int unsigned width);
    return settle_last(width) + 32'd1;
  endfunction

endpackage

// File: rtl/slowclk_settle_timer.sv
`timescale 1ns/1ps
module slowclk_settle_timer
  import slowclk_pkg::*;
#(
  parameter int unsigned CNT_W = 15
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic wrap
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(settle_last(CNT_W));

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt <= '0;
    else if (run) cnt <= cnt + 1'b1;
    else          cnt <= '0;
  end

  assign wrap = run && (cnt == LAST);

endmodule

// File: rtl/slowclk_seq_fsm.sv
`timescale 1ns/1ps
module slowclk_seq_fsm
  import slowclk_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start_wr,
  input  logic settle_wrap,
  input  logic xtal_ack,
  output logic settle_run,
  output logic pinmux_req,
  output logic xtal_en,
  output logic sel_xtal,
  output logic done
);
  seq_state_e state, state_nx;

  always_comb begin
    state_nx = state;
    unique case (state)
      SQ_IDLE:     if (start_wr)    state_nx = SQ_PINMUX;
      SQ_PINMUX:                    state_nx = SQ_SETTLE;
      SQ_SETTLE:   if (settle_wrap) state_nx = SQ_HANDOVER;
      SQ_HANDOVER: if (xtal_ack)    state_nx = SQ_XTAL;
      SQ_XTAL:                      state_nx = SQ_XTAL;
      default:                      state_nx = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= SQ_IDLE;
    else        state <= state_nx;
  end

  assign pinmux_req = (state != SQ_IDLE);
  assign xtal_en    = (state == SQ_SETTLE) || (state == SQ_HANDOVER) || (state == SQ_XTAL);
  assign settle_run = (state == SQ_SETTLE);
  assign sel_xtal   = (state == SQ_HANDOVER) || (state == SQ_XTAL);
  assign done       = (state == SQ_XTAL);

  // R2
  pinmux_lead_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(xtal_en) |-> $past(pinmux_req));

  // R3
  settle_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sel_xtal) |-> $past(settle_wrap));

  // R7
  done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> done);

endmodule

// File: rtl/slowclk_sync2.sv
`timescale 1ns/1ps
module slowclk_sync2 #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh <= '0;
    else        sh <= {sh[STAGES-2:0], d};
  end

  assign q = sh[STAGES-1];

endmodule

// File: rtl/slowclk_gf_leg.sv
`timescale 1ns/1ps
module slowclk_gf_leg #(
  parameter int unsigned STAGES      = 2,
  parameter bit          ON_AT_RESET = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic want,
  input  logic other_on,
  output logic on
);
  logic [STAGES-1:0] sh;

  // falling-edge chain: connect/disconnect only while this source is low
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) sh <= {STAGES{ON_AT_RESET}};
    else        sh <= {sh[STAGES-2:0], want & ~other_on};
  end

  assign on = sh[STAGES-1];

endmodule

// File: rtl/slowclk_gf_mux.sv
`timescale 1ns/1ps
module slowclk_gf_mux #(
  parameter int unsigned STAGES = 2
) (
  input  logic rst_n,
  input  logic rc_clk,
  input  logic xtal_clk,
  input  logic sel_xtal,
  output logic slow_clk,
  output logic rc_on,
  output logic xtal_on
);
  localparam int unsigned LEGS = 2;

  logic [LEGS-1:0] src_clk, want, on;

  assign src_clk = {xtal_clk, rc_clk};
  assign want    = {sel_xtal, ~sel_xtal};

  for (genvar g = 0; g < LEGS; g++) begin : g_leg
    slowclk_gf_leg #(
      .STAGES      (STAGES),
      .ON_AT_RESET (g == 0)
    ) u_leg (
      .clk      (src_clk[g]),
      .rst_n    (rst_n),
      .want     (want[g]),
      .other_on (on[LEGS-1-g]),
      .on       (on[g])
    );
  end

  assign slow_clk = |(src_clk & on);
  assign rc_on    = on[0];
  assign xtal_on  = on[1];

  // R4
  always_comb begin
    if (rst_n) begin
      no_overlap_chk: assert (!(on[0] && on[1]));
    end
  end

endmodule

// File: rtl/slowclk_src_seq.sv
`timescale 1ns/1ps
module slowclk_src_seq
  import slowclk_pkg::*;
#(
  parameter int unsigned SETTLE_W = 15,
  parameter int unsigned SYNC_N   = 2
) (
  input  logic por_n,
  input  logic rc_clk,
  input  logic xtal_clk,
  input  logic ctrl_wr,
  input  logic ctrl_xtalsel,
  input  logic mode_wr,
  input  logic mode_bypass,
  output logic rc_en,
  output logic xtal_en,
  output logic xtal_bypass,
  output logic pinmux_req,
  output logic slow_clk,
  output logic sw_done
);
  logic start_wr, settle_run, settle_wrap;
  logic sel_xtal, xtal_ack, rc_on, xtal_on;
  logic bypass_q;

  assign start_wr = ctrl_wr && ctrl_xtalsel;

  slowclk_settle_timer #(.CNT_W(SETTLE_W)) u_timer (
    .clk   (rc_clk),
    .rst_n (por_n),
    .run   (settle_run),
    .wrap  (settle_wrap)
  );

  slowclk_seq_fsm u_fsm (
    .clk         (rc_clk),
    .rst_n       (por_n),
    .start_wr    (start_wr),
    .settle_wrap (settle_wrap),
    .xtal_ack    (xtal_ack),
    .settle_run  (settle_run),
    .pinmux_req  (pinmux_req),
    .xtal_en     (xtal_en),
    .sel_xtal    (sel_xtal),
    .done        (sw_done)
  );

  slowclk_gf_mux #(.STAGES(SYNC_N)) u_mux (
    .rst_n    (por_n),
    .rc_clk   (rc_clk),
    .xtal_clk (xtal_clk),
    .sel_xtal (sel_xtal),
    .slow_clk (slow_clk),
    .rc_on    (rc_on),
    .xtal_on  (xtal_on)
  );

  slowclk_sync2 #(.STAGES(SYNC_N)) u_ack_sync (
    .clk   (rc_clk),
    .rst_n (por_n),
    .d     (xtal_on),
    .q     (xtal_ack)
  );

  always_ff @(posedge rc_clk or negedge por_n) begin
    if (!por_n)                     bypass_q <= 1'b0;
    else if (mode_wr && !pinmux_req) bypass_q <= mode_bypass;
  end

  assign xtal_bypass = bypass_q;
  assign rc_en       = !sw_done;

  // R5
  rc_detached_chk: assert property (@(posedge rc_clk) disable iff (!por_n)
    sw_done |-> !rc_on);

  // R9
  bypass_locked_chk: assert property (@(posedge rc_clk) disable iff (!por_n)
    (pinmux_req && $past(pinmux_req)) |-> $stable(xtal_bypass));

endmodule

// File: tb/slowclk_src_seq_test.sv
`timescale 1ns/1ps
module slowclk_src_seq_test;

  localparam int SETTLE = 1 << 15;

  logic por_n, rc_clk, xtal_clk;
  logic ctrl_wr, ctrl_xtalsel, mode_wr, mode_bypass;
  logic rc_en, xtal_en, xtal_bypass, pinmux_req, slow_clk, sw_done;

  int checks = 0, failures = 0, glitches = 0, cyc = 0;
  bit finished = 0;
  realtime last_t = 0;

  typedef struct { int at; int sig; logic val; string req; } exp_t;
  exp_t q[$];

  slowclk_src_seq uut (
    .por_n(por_n), .rc_clk(rc_clk), .xtal_clk(xtal_clk),
    .ctrl_wr(ctrl_wr), .ctrl_xtalsel(ctrl_xtalsel),
    .mode_wr(mode_wr), .mode_bypass(mode_bypass),
    .rc_en(rc_en), .xtal_en(xtal_en), .xtal_bypass(xtal_bypass),
    .pinmux_req(pinmux_req), .slow_clk(slow_clk), .sw_done(sw_done)
  );

  // oscillator models: each runs only while enabled (RC runs in reset)
  initial rc_clk = 0;
  always #2 rc_clk = (rc_en !== 1'b0 || por_n !== 1'b1) ? ~rc_clk : 1'b0;
  initial xtal_clk = 0;
  always #7.3 xtal_clk = (xtal_en === 1'b1) ? ~xtal_clk : 1'b0;

  function automatic logic sig_val(int s);
    case (s)
      0: return pinmux_req;
      1: return xtal_en;
      2: return rc_en;
      3: return sw_done;
      4: return xtal_bypass;
      default: return slow_clk;
    endcase
  endfunction

  task automatic chk(string req, string what, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%b expected=%b t=%0t", req, what, act, exp, $time);
    end
  endtask

  task automatic push(int at, int sig, logic val, string req);
    exp_t e;
    e.at = at; e.sig = sig; e.val = val; e.req = req;
    q.push_back(e);
  endtask

  // monitor: cycle count and scoreboard compare, 1 ns after each rising edge
  always @(posedge rc_clk) begin
    if (por_n === 1'b1) begin
      cyc = cyc + 1;
      #1;
      for (int i = q.size() - 1; i >= 0; i--) begin
        if (q[i].at == cyc) begin
          chk(q[i].req, $sformatf("sig%0d@cyc%0d", q[i].sig, cyc), sig_val(q[i].sig), q[i].val);
          q.delete(i);
        end else if (q[i].at < cyc) begin
          chk(q[i].req, "missed sample", 1'b0, 1'b1);
          q.delete(i);
        end
      end
    end
  end

  // glitch monitor for R4: min phase is half the rc period (2 ns)
  always @(posedge por_n) last_t = 0;
  always @(slow_clk) begin
    if (por_n === 1'b1 && last_t > 0 && ($realtime - last_t) < 1.9) glitches++;
    last_t = $realtime;
  end

  // driver tasks: strobe set on a falling edge, cleared after the taking edge
  task automatic wr_ctrl(logic sel, output int w);
    @(negedge rc_clk);
    ctrl_wr = 1; ctrl_xtalsel = sel; w = cyc;
    @(posedge rc_clk); #0.5;
    ctrl_wr = 0; ctrl_xtalsel = 0;
  endtask

  task automatic wr_mode(logic byp, output int w);
    @(negedge rc_clk);
    mode_wr = 1; mode_bypass = byp; w = cyc;
    @(posedge rc_clk); #0.5;
    mode_wr = 0; mode_bypass = 0;
  endtask

  task automatic summary;
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    #600000;
    checks++; failures++;
    $display("FAIL watchdog expired actual=running expected=finished");
    summary();
  end

  initial begin
    int w, n;
    por_n = 0; ctrl_wr = 0; ctrl_xtalsel = 0; mode_wr = 0; mode_bypass = 0;
    #9;
    chk("R1", "rc_en in reset", rc_en, 1'b1);
    chk("R1", "xtal_en in reset", xtal_en, 1'b0);
    #11 por_n = 1;
    @(posedge rc_clk); #1;
    chk("R1", "rc_en", rc_en, 1'b1);
    chk("R1", "xtal_en", xtal_en, 1'b0);
    chk("R1", "pinmux_req", pinmux_req, 1'b0);
    chk("R1", "xtal_bypass", xtal_bypass, 1'b0);
    chk("R1", "sw_done", sw_done, 1'b0);
    chk("R1", "slow_clk high with rc", slow_clk, 1'b1);
    @(negedge rc_clk); #1;
    chk("R1", "slow_clk low with rc", slow_clk, 1'b0);

    // R2: write without crystal-select does nothing
    wr_ctrl(1'b0, w);
    push(w + 1, 0, 1'b0, "R2"); push(w + 2, 0, 1'b0, "R2");
    push(w + 2, 1, 1'b0, "R2");

    // R9: bypass loads while idle
    wr_mode(1'b1, w);
    push(w + 1, 4, 1'b1, "R9");

    // R2/R3: start
    wr_ctrl(1'b1, w);
    n = w + 1;
    push(n, 0, 1'b1, "R2");
    push(n, 1, 1'b0, "R2");
    push(n + 1, 1, 1'b1, "R2");
    push(n + SETTLE, 2, 1'b1, "R3");
    push(n + SETTLE + 1, 3, 1'b0, "R3");
    push(n + SETTLE + 2, 5, 1'b1, "R3");
    push(n + SETTLE + 3, 5, 1'b0, "R3");

    while (cyc < n + 100) @(negedge rc_clk);
    // R7: second select during settle must not restart the sequence
    wr_ctrl(1'b1, w);
    push(w + 2, 1, 1'b1, "R7"); push(w + 2, 0, 1'b1, "R7");
    // R9: mode write after start ignored
    wr_mode(1'b0, w);
    push(w + 2, 4, 1'b1, "R9");
    push(n + SETTLE - 1, 4, 1'b1, "R9");

    wait (q.size() == 0);
    // R6: done within a bounded time after handover start
    for (int i = 0; i < 300; i++) begin
      if (sw_done === 1'b1) break;
      #1;
    end
    chk("R6", "sw_done after handover", sw_done, 1'b1);
    #50;
    chk("R5", "rc_en off", rc_en, 1'b0);
    chk("R5", "xtal_en kept", xtal_en, 1'b1);
    for (int i = 0; i < 3; i++) begin
      @(posedge xtal_clk); #2;
      chk("R5", "slow_clk high with xtal", slow_clk, 1'b1);
      @(negedge xtal_clk); #2;
      chk("R5", "slow_clk low with xtal", slow_clk, 1'b0);
    end

    // R7: writes after completion ignored
    ctrl_wr = 1; ctrl_xtalsel = 1; mode_wr = 1; mode_bypass = 0;
    #40;
    ctrl_wr = 0; ctrl_xtalsel = 0; mode_wr = 0;
    #20;
    chk("R7", "sw_done stays", sw_done, 1'b1);
    chk("R7", "rc_en stays off", rc_en, 1'b0);
    chk("R7", "bypass unchanged", xtal_bypass, 1'b1);
    @(posedge xtal_clk); #2;
    chk("R7", "slow_clk still xtal", slow_clk, 1'b1);

    chk("R4", "glitch count", (glitches == 0), 1'b1);

    // R8: power-on reset restores RC operation
    por_n = 0; #10; por_n = 1;
    #1;
    chk("R8", "rc_en", rc_en, 1'b1);
    chk("R8", "sw_done", sw_done, 1'b0);
    chk("R8", "xtal_en", xtal_en, 1'b0);
    chk("R8", "pinmux_req", pinmux_req, 1'b0);
    chk("R8", "xtal_bypass", xtal_bypass, 1'b0);
    @(posedge rc_clk); #1;
    chk("R8", "slow_clk high with rc", slow_clk, 1'b1);
    @(negedge rc_clk); #1;
    chk("R8", "slow_clk low with rc", slow_clk, 1'b0);

    summary();
  end

endmodule